// File: doc/BRIEF.md
# Timer Compare Channel with Event Flag

This block is the compare stage that sits beside an 8-bit timer counter. The counter itself lives elsewhere. It feeds this block its running value, a one-cycle timer-clock enable, and two strobes that mark its highest and lowest value. On every cycle the channel compares the count against an effective compare value. The result drives three things: an event flag, an interrupt request, and a waveform pin whose behaviour depends on a waveform mode and a two-bit output action field.

The timer clock is a single-cycle enable (`tick`) on the system clock. Flag setting, pin updates, direction tracking and loading of the compare buffer all happen only on `tick` edges. Software can clear the flag in two ways: the interrupt controller pulses `irq_ack`, or software writes a one (`flag_clr`). A pulse on `cnt_wr` reports that software has just written the counter, and it masks the next compare event so that this write cannot create a spurious one.

Waveform mode encoding on `wave_mode`:
- 0: free count.
- 1: phase-correct PWM (up/down counter).
- 2: clear-on-match count.
- 3: fast PWM (up counter that wraps).

Modes 1 and 3 are the PWM modes.

Output action encoding on `out_mode`:
- 0: pin off.
- 1: toggle.
- 2: clear, or non-inverting in PWM modes.
- 3: set, or inverting in PWM modes.

Top module: `ocu_channel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `flag`, `irq`, `wave_out` and `cmp_value` are all 0.
- R2: `match` is 1 in any cycle where `count` equals `cmp_value` and no suppression from R10 is active.
- R3: A `tick` in a cycle with `match`=1 makes `flag` read 1 from the following cycle. The match sets the flag at the timer edge, never combinationally.
- R4: `irq` is `flag` when `irq_en`=1, and 0 when `irq_en`=0.
- R5: `irq_ack`=1 or `flag_clr`=1 clears `flag` at the next edge. If a flag-setting event (R3) falls in the same cycle, the set wins and `flag` stays 1.
- R6: In modes 0 and 2, a `tick` with `match` acts on the pin according to `out_mode`: 1 toggles it, 2 drives it to 0, 3 drives it to 1. With `out_mode`=0, `wave_oe` and `wave_out` are 0 in every mode.
- R7: In mode 3 with `out_mode` 2, a `tick` with `at_top` drives the pin to 1, and otherwise a `tick` with `match` drives it to 0. The top event wins, so a compare value at top gives a constant 1. `out_mode` 3 inverts this. `out_mode` 1 disconnects the pin (`wave_oe`=0).
- R8: In mode 1 with `out_mode` 2, a matching `tick` does the following, checked in this order:
  - at top: drives the pin to 1;
  - at bottom: drives it to 0;
  - while counting down: drives it to 1;
  - while counting up: drives it to 0.
  The direction turns down at a `tick` with `at_top` and turns up at a `tick` with `at_bottom`. `out_mode` 3 inverts the levels, and `out_mode` 1 disconnects the pin.
- R9: In modes 0 and 2, a `cmp_wr` shows on `cmp_value` in the next cycle. In modes 1 and 3, the write goes to a buffer, and `cmp_value` loads from that buffer only at a `tick` with `at_top`.
- R10: A `cnt_wr` pulse forces `match` to 0 from its own cycle up to and including the first `tick` in a later cycle.
- R11: Without a `tick`, `flag` never rises and the pin level does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer-clock enable, one cycle wide |
| count | input | W | Current counter value |
| at_top | input | 1 | Counter is at its highest value |
| at_bottom | input | 1 | Counter is at zero |
| wave_mode | input | 2 | Waveform mode (0 free, 1 phase-correct, 2 clear-on-match, 3 fast) |
| out_mode | input | 2 | Pin action (0 off, 1 toggle, 2 clear/non-inverting, 3 set/inverting) |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | W | Compare register write data |
| cnt_wr | input | 1 | Software wrote the counter this cycle |
| flag_clr | input | 1 | Software writes one to the flag bit |
| irq_en | input | 1 | Compare interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge (the handler runs) |
| match | output | 1 | Count equals effective compare value |
| cmp_value | output | W | Effective compare value |
| flag | output | 1 | Compare event flag |
| irq | output | 1 | Interrupt request |
| wave_out | output | 1 | Waveform pin level |
| wave_oe | output | 1 | Waveform pin connected |

## Verification
Two different things can coincide in one cycle: a flag set, from a `tick` that finds a match, and a flag clear, from `irq_ack` or `flag_clr`. A second coincidence is the top or bottom strobe with a match, which happens whenever the compare value sits at an extreme.

The bench provokes the first by placing the acknowledge exactly on the matching `tick`. It then expects the flag to survive.

For the second, it sweeps every compare value of a 4-bit configuration in both PWM modes, and compares the pin against a duty computed in arithmetic from the count and its direction. Constant high and constant low at the extremes are the outcomes judged.

// File: rtl/ocu_pkg.sv
// Package: shared encodings for the compare channel.
// Assumes two-bit mode fields; mode bit 0 set means a PWM mode.
package ocu_pkg;

    typedef enum logic [1:0] {
        WG_FREE  = 2'd0,
        WG_PHASE = 2'd1,
        WG_CLR   = 2'd2,
        WG_FAST  = 2'd3
    } wg_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLEAR  = 2'd2,
        OM_SET    = 2'd3
    } om_e;

    // True for the two PWM waveform modes
    function automatic logic is_pwm(wg_mode_e m);
        return (m == WG_PHASE) || (m == WG_FAST);
    endfunction

endpackage

// File: rtl/ocu_cmp_path.sv
// Module: compare register path and comparator.
// Holds a write buffer and the effective compare value. In PWM modes the
// effective value loads from the buffer at a top tick; otherwise writes
// go straight through. A counter write masks the comparator until the
// first tick after it. Assumes tick is a one-cycle enable.
module ocu_cmp_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm,
    input  logic [W-1:0] count,
    input  logic         at_top,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         cnt_wr,
    output logic [W-1:0] cmp_active,
    output logic         match
);

    logic [W-1:0] cmp_buf;
    logic         masked;

    // Buffer and effective compare value update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buf    <= '0;
            cmp_active <= '0;
        end else begin
            if (cmp_wr) begin
                cmp_buf <= cmp_wdata;
            end
            if (!pwm && cmp_wr) begin
                cmp_active <= cmp_wdata;
            end else if (pwm && tick && at_top) begin
                cmp_active <= cmp_buf;
            end
        end
    end

    // Counter-write mask: held until the first later tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked <= 1'b0;
        end else if (cnt_wr) begin
            masked <= 1'b1;
        end else if (tick) begin
            masked <= 1'b0;
        end
    end

    // Equality comparator gated by the mask
    always_comb begin
        match = (count == cmp_active) && !masked && !cnt_wr;
    end

endmodule

// File: rtl/ocu_flag.sv
// Module: compare event flag and interrupt request.
// The flag sets at a tick that sees a match. It clears on acknowledge or
// on a write of one; a set in the same cycle wins over a clear.
module ocu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic flag_clr,
    input  logic irq_ack,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    // Flag register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (tick && match) begin
            flag <= 1'b1;
        end else if (flag_clr || irq_ack) begin
            flag <= 1'b0;
        end
    end

    // Interrupt request gated by the enable
    always_comb begin
        irq = flag && irq_en;
    end

endmodule

// File: rtl/ocu_wavegen.sv
// Module: waveform pin generator.
// Non-PWM modes act on match only. Fast PWM sets at top and clears on
// match, with top winning. Phase-correct PWM follows the count direction,
// and top/bottom override it so extreme compare values give steady levels.
// Assumes at_top/at_bottom are valid in the same cycle as tick.
module ocu_wavegen
    import ocu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     match,
    input  logic     at_top,
    input  logic     at_bottom,
    input  wg_mode_e wmode,
    input  om_e      omode,
    output logic     wave_out,
    output logic     wave_oe
);

    logic wave_q;
    logic wave_nxt;
    logic dir_down;
    logic pwm;
    logic inv;

    // Pin enable and polarity decode
    always_comb begin
        pwm     = is_pwm(wmode);
        inv     = (omode == OM_SET);
        wave_oe = (omode != OM_OFF) && !(pwm && omode == OM_TOGGLE);
    end

    // Next pin level for the current tick
    always_comb begin
        wave_nxt = wave_q;
        if (tick && wave_oe) begin
            if (!pwm) begin
                if (match) begin
                    case (omode)
                        OM_TOGGLE: wave_nxt = ~wave_q;
                        OM_CLEAR:  wave_nxt = 1'b0;
                        OM_SET:    wave_nxt = 1'b1;
                        default:   wave_nxt = wave_q;
                    endcase
                end
            end else if (wmode == WG_FAST) begin
                if (at_top) begin
                    wave_nxt = ~inv;
                end else if (match) begin
                    wave_nxt = inv;
                end
            end else if (match) begin
                if (at_top) begin
                    wave_nxt = ~inv;
                end else if (at_bottom) begin
                    wave_nxt = inv;
                end else begin
                    wave_nxt = dir_down ? ~inv : inv;
                end
            end
        end
    end

    // Pin level and count direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q   <= 1'b0;
            dir_down <= 1'b0;
        end else begin
            wave_q <= wave_nxt;
            if (tick && at_top) begin
                dir_down <= 1'b1;
            end else if (tick && at_bottom) begin
                dir_down <= 1'b0;
            end
        end
    end

    // Disconnected pin reads low
    always_comb begin
        wave_out = wave_oe && wave_q;
    end

endmodule

// File: rtl/ocu_channel.sv
// Module: top of the timer compare channel.
// Joins the compare path, the event flag and the waveform generator.
// Assumes the counter, its top/bottom strobes and tick come from outside.
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wave_mode,
    input  logic [1:0]   out_mode,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         cnt_wr,
    input  logic         flag_clr,
    input  logic         irq_en,
    input  logic         irq_ack,
    output logic         match,
    output logic [W-1:0] cmp_value,
    output logic         flag,
    output logic         irq,
    output logic         wave_out,
    output logic         wave_oe
);

    wg_mode_e wmode;
    om_e      omode;
    logic     pwm;

    // Mode field decode
    always_comb begin
        wmode = wg_mode_e'(wave_mode);
        omode = om_e'(out_mode);
        pwm   = is_pwm(wmode);
    end

    ocu_cmp_path #(.W(W)) i_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pwm        (pwm),
        .count      (count),
        .at_top     (at_top),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .cnt_wr     (cnt_wr),
        .cmp_active (cmp_value),
        .match      (match)
    );

    ocu_flag i_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .match    (match),
        .flag_clr (flag_clr),
        .irq_ack  (irq_ack),
        .irq_en   (irq_en),
        .flag     (flag),
        .irq      (irq)
    );

    ocu_wavegen i_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .match     (match),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .wmode     (wmode),
        .omode     (omode),
        .wave_out  (wave_out),
        .wave_oe   (wave_oe)
    );

endmodule

// File: rtl/ocu_channel_chk.sv
// Module: property checker for the compare channel, bound to the top.
// Observes ports only.
module ocu_channel_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         at_top,
    input logic [1:0]   wave_mode,
    input logic [1:0]   out_mode,
    input logic         cnt_wr,
    input logic         flag_clr,
    input logic         irq_en,
    input logic         irq_ack,
    input logic         match,
    input logic [W-1:0] cmp_value,
    input logic         flag,
    input logic         irq,
    input logic         wave_out,
    input logic         wave_oe
);

    a_r3_flag_follows_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> flag);

    a_r11_flag_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick && match));

    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack || flag_clr) && !(tick && match)) |=> !flag);

    a_r6_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'd0) |-> (!wave_out && !wave_oe));

    a_r10_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |-> !match);

    a_r9_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode[0] && !(tick && at_top)) |=> $stable(cmp_value));

    a_r11_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && wave_oe) |=> (!wave_oe || wave_out == $past(wave_out)));

endmodule

bind ocu_channel ocu_channel_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .at_top    (at_top),
    .wave_mode (wave_mode),
    .out_mode  (out_mode),
    .cnt_wr    (cnt_wr),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .irq_ack   (irq_ack),
    .match     (match),
    .cmp_value (cmp_value),
    .flag      (flag),
    .irq       (irq),
    .wave_out  (wave_out),
    .wave_oe   (wave_oe)
);

// File: tb/test_ocu_channel.sv
`timescale 1ns/1ps
// Bench: 4-bit configuration, sweeping every compare value in each mode.
module test_ocu_channel;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick;
    logic [W-1:0] count;
    logic         at_top;
    logic         at_bottom;
    logic [1:0]   wave_mode;
    logic [1:0]   out_mode;
    logic         cmp_wr;
    logic [W-1:0] cmp_wdata;
    logic         cnt_wr;
    logic         flag_clr;
    logic         irq_en;
    logic         irq_ack;
    logic         match;
    logic [W-1:0] cmp_value;
    logic         flag;
    logic         irq;
    logic         wave_out;
    logic         wave_oe;

    int n_chk  = 0;
    int n_fail = 0;

    logic [3:0] cnt;
    bit         up;

    always #2 clk = ~clk;

    ocu_channel #(.W(W)) i_ocu_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
        .at_top(at_top), .at_bottom(at_bottom), .wave_mode(wave_mode),
        .out_mode(out_mode), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cnt_wr(cnt_wr), .flag_clr(flag_clr), .irq_en(irq_en),
        .irq_ack(irq_ack), .match(match), .cmp_value(cmp_value),
        .flag(flag), .irq(irq), .wave_out(wave_out), .wave_oe(wave_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic put_count(input logic [3:0] v);
        count     = v;
        at_top    = (v == 4'hF);
        at_bottom = (v == 4'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 0; cmp_wr = 0; cmp_wdata = '0; cnt_wr = 0;
        flag_clr = 0; irq_en = 0; irq_ack = 0; wave_mode = 2'd0; out_mode = 2'd0;
        cnt = 0; up = 1; put_count(0);
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic wr_cmp(input logic [3:0] v);
        cmp_wr = 1; cmp_wdata = v;
        cyc();
        cmp_wr = 0;
        cyc();
    endtask

    task automatic pulse_tick();
        tick = 1;
        cyc();
        tick = 0;
    endtask

    // One timer step of an up counter that wraps
    task automatic step_fast();
        pulse_tick();
        cnt = cnt + 1;
        put_count(cnt);
        cyc();
    endtask

    // One timer step of an up/down counter
    task automatic step_phase();
        pulse_tick();
        if (up) begin
            if (cnt == 4'hF) begin cnt = 4'hE; up = 0; end
            else cnt = cnt + 1;
        end else begin
            if (cnt == 4'h0) begin cnt = 4'h1; up = 1; end
            else cnt = cnt - 1;
        end
        put_count(cnt);
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0; tick = 0; cmp_wr = 0; cmp_wdata = '0; cnt_wr = 0;
        flag_clr = 0; irq_en = 1; irq_ack = 0; wave_mode = 2'd0; out_mode = 2'd3;
        put_count(4'h7);
        cyc(); cyc();
        chk("R1 flag", int'(flag), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 wave_out", int'(wave_out), 0);
        chk("R1 cmp_value", int'(cmp_value), 0);
        do_reset();
        chk("R1 flag after release", int'(flag), 0);
        chk("R1 cmp after release", int'(cmp_value), 0);

        // R9: non-PWM write shows next cycle
        cmp_wr = 1; cmp_wdata = 4'h5;
        cyc();
        cmp_wr = 0;
        chk("R9 direct write", int'(cmp_value), 5);

        // R2/R11: match without tick leaves the flag alone
        put_count(4'h5);
        #1;
        chk("R2 match on equal", int'(match), 1);
        cyc(); cyc();
        chk("R11 no tick no flag", int'(flag), 0);
        put_count(4'h6);
        #1;
        chk("R2 no match on unequal", int'(match), 0);

        // R3: flag after matching tick
        put_count(4'h5);
        pulse_tick();
        chk("R3 flag set", int'(flag), 1);
        chk("R4 irq masked", int'(irq), 0);
        irq_en = 1;
        #1;
        chk("R4 irq enabled", int'(irq), 1);

        // R5: write-one and acknowledge clears
        put_count(4'h6);
        flag_clr = 1; cyc(); flag_clr = 0;
        chk("R5 write one clears", int'(flag), 0);
        put_count(4'h5);
        pulse_tick();
        put_count(4'h6);
        irq_ack = 1; cyc(); irq_ack = 0;
        chk("R5 ack clears", int'(flag), 0);
        chk("R4 irq follows flag", int'(irq), 0);

        // R5: set and acknowledge in the same cycle
        put_count(4'h5);
        tick = 1; irq_ack = 1;
        cyc();
        tick = 0; irq_ack = 0;
        chk("R5 set wins over ack", int'(flag), 1);
        put_count(4'h6);
        flag_clr = 1; cyc(); flag_clr = 0;

        // R10: counter write masks the next tick's match
        put_count(4'h5);
        cnt_wr = 1;
        #1;
        chk("R10 match masked in write cycle", int'(match), 0);
        cyc();
        cnt_wr = 0;
        #1;
        chk("R10 match masked until tick", int'(match), 0);
        pulse_tick();
        chk("R10 no flag from masked tick", int'(flag), 0);
        #1;
        chk("R10 mask released", int'(match), 1);
        pulse_tick();
        chk("R10 flag after release", int'(flag), 1);

        // R9: PWM buffer loads only at a top tick
        wave_mode = 2'd3; out_mode = 2'd2;
        put_count(4'h3);
        wr_cmp(4'h9);
        chk("R9 buffered hold", int'(cmp_value), 5);
        pulse_tick();
        chk("R9 hold after plain tick", int'(cmp_value), 5);
        put_count(4'hF);
        pulse_tick();
        chk("R9 load at top", int'(cmp_value), 9);

        // R6/R7: disconnected pin
        out_mode = 2'd0;
        #1;
        chk("R6 off oe", int'(wave_oe), 0);
        chk("R6 off level", int'(wave_out), 0);
        out_mode = 2'd1;
        #1;
        chk("R7 toggle not in PWM", int'(wave_oe), 0);

        // R6: non-PWM sweep over compare values and actions
        for (int om = 1; om <= 3; om++) begin
            for (int k = 0; k < 16; k++) begin
                int nm;
                do_reset();
                wave_mode = (k % 2 == 0) ? 2'd0 : 2'd2;
                out_mode = om[1:0];
                wr_cmp(k[3:0]);
                nm = 0;
                for (int s = 0; s < 40; s++) begin
                    int e;
                    if (cnt == k[3:0]) nm++;
                    step_fast();
                    e = (om == 1) ? (nm % 2) : (om == 2) ? 0 : (nm > 0 ? 1 : 0);
                    chk("R6 non-PWM pin", int'(wave_out), e);
                end
            end
        end

        // R7: fast PWM sweep
        for (int om = 2; om <= 3; om++) begin
            for (int k = 0; k < 16; k++) begin
                do_reset();
                wave_mode = 2'd3; out_mode = om[1:0];
                wr_cmp(k[3:0]);
                for (int s = 0; s < 32; s++) step_fast();
                for (int s = 0; s < 16; s++) begin
                    int e;
                    step_fast();
                    e = ((cnt <= k[3:0]) ? 1 : 0) ^ (om == 3 ? 1 : 0);
                    chk("R7 fast PWM pin", int'(wave_out), e);
                end
            end
        end

        // R8: phase-correct sweep
        for (int om = 2; om <= 3; om++) begin
            for (int k = 0; k < 16; k++) begin
                do_reset();
                wave_mode = 2'd1; out_mode = om[1:0];
                wr_cmp(k[3:0]);
                for (int s = 0; s < 60; s++) step_phase();
                for (int s = 0; s < 30; s++) begin
                    int e;
                    step_phase();
                    if (up) e = (cnt <= k[3:0]) ? 1 : 0;
                    else    e = (cnt <  k[3:0]) ? 1 : 0;
                    e = e ^ (om == 3 ? 1 : 0);
                    chk("R8 phase PWM pin", int'(wave_out), e);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule